// File: doc/BRIEF.md
# Packet Command Sequencer

This block is the top-level control sequencer of an instrument controller attached to a network. It starts in a hard-reset state and sends a status reply. It then waits in idle until the receive FIFO reports data. It reads one packet and then dispatches on the command in that packet. The possible actions are a sensor query, a DAC load, a hard reset or a soft reset, and each is followed by the matching reply. The query, program and transmit engines are separate units. The sequencer drives each one with a one-cycle start strobe and waits for a one-cycle done pulse from it.

The 3-bit state code carries meaning and is available at the ports:

| Code | State |
|------|-------|
| 000 | hard reset |
| 001 | soft reset |
| 010 | idle |
| 011 | packet reader |
| 100 | query |
| 110 | DAC program |
| 101 | status reply |
| 111 | DAC-value reply |

Both reply states match 1X1, and the middle bit selects the reply kind. Both reset states match 00X, and both lead directly to the status reply.

Each packet arrives as a byte stream with a valid flag and an end-of-packet flag. The sequencer skips a fixed-length header, except for the six source-address bytes at header offsets 6 to 11. It then reads a location byte, a command byte and an optional argument byte, and consumes the rest of the packet. The parameter `HDR_LEN` must be at least 12.

Top module: `pkt_cmd_sequencer`

## Requirements
- R1: A synchronous reset forces state 000 with `fresh` entry. While in 000, `chip_rst` is all ones. One cycle later the state is 101, with a `tx_start` pulse and `tx_kind`=0.
- R2: In idle (010) the state holds while `rx_nonempty` is low. It moves to 011 on the clock edge at which `rx_nonempty` is high.
- R3: In 011, byte index `HDR_LEN` is the location and `HDR_LEN`+1 is the command. `HDR_LEN`+2 is the argument; when that byte is absent, the argument is taken as 0. Header bytes 6..11 form the source address, with the first byte as the most significant.
- R4: A packet is rejected in any of these cases:
  - the location differs from `my_loc`;
  - the command is not one of the four codes;
  - the packet ends before the command byte;
  - a 'P' or 'R' command has no argument byte.
  A rejected packet is read to its end and the state returns to 010 on the edge after the end byte. No start strobe is issued, and `cmd_type`, `cmd_arg` and `peer_mac` keep their values.
- R5: Command 'Q' (0x51) leads to 100 with a one-cycle `qry_start` on entry. After `qry_done` the state moves to 101.
- R6: Command 'P' (0x50) latches the argument into `cmd_arg` and leads to 110 with a one-cycle `prg_start`. After `prg_done` the state moves to 111.
- R7: States 101 and 111 issue a one-cycle `tx_start` on entry, with `tx_kind` 0 (status) and 1 (DAC values) respectively. After `tx_done` the state returns to 010. Only one start strobe is high at a time.
- R8: Command 'H' (0x48) leads to 000 and then to 101. Command 'R' (0x52) leads to 001, where `chip_rst` equals the argument mask for one cycle. It also latches the source address into `peer_mac`, and then leads to 101. `peer_mac` changes only on entry to 001.
- R9: A done pulse has no effect in the cycle of its own start strobe or in any state that does not wait for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_vld | input | 1 | `rx_byte` valid this cycle |
| rx_byte | input | 8 | Packet byte from receive FIFO |
| rx_eop | input | 1 | Current byte is last of packet |
| my_loc | input | 8 | Local location identifier |
| qry_done | input | 1 | Query engine finished |
| prg_done | input | 1 | DAC program engine finished |
| tx_done | input | 1 | Transmit engine finished |
| qry_start | output | 1 | Start query engine |
| prg_start | output | 1 | Start DAC program engine |
| tx_start | output | 1 | Start transmit engine |
| tx_kind | output | 1 | Reply kind: 0 status, 1 DAC values |
| chip_rst | output | CHIP_W | Reset request to peripheral chips |
| cmd_type | output | 8 | Last accepted command byte |
| cmd_arg | output | 8 | Last accepted argument byte |
| peer_mac | output | 48 | Requester address latched on soft reset |
| state_o | output | 3 | Current state code |

## Verification
The bench targets several cases where a packet must be rejected:
- a location mismatch, an unknown command, a short packet cut inside the header, and a 'P' command without its argument byte;
- in each case, a faulty decoder would dispatch or overwrite the latched fields instead of draining to idle.

It checks whether done pulses are honoured when they arrive in the strobe cycle or while idle. A sequencer that honours them would skip a sub-unit or leave idle.

A soft reset with a known address checks the byte order in `peer_mac` and the one-cycle mask on `chip_rst`. Gapped byte streams with trailing bytes check that the end marker, not the byte count, ends the read.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    typedef enum logic [2:0] {
        ST_HARD    = 3'b000,
        ST_SOFT    = 3'b001,
        ST_IDLE    = 3'b010,
        ST_READ    = 3'b011,
        ST_QUERY   = 3'b100,
        ST_TX_STAT = 3'b101,
        ST_PROG    = 3'b110,
        ST_TX_DAC  = 3'b111
    } seq_state_e;

    localparam logic [7:0] CMD_QUERY = 8'h51;
    localparam logic [7:0] CMD_PROG  = 8'h50;
    localparam logic [7:0] CMD_HARD  = 8'h48;
    localparam logic [7:0] CMD_SOFT  = 8'h52;

    localparam int MAC_BYTES   = 6;
    localparam int SRC_MAC_OFS = 6;
    localparam int MAC_W       = 8 * MAC_BYTES;

    typedef struct packed {
        logic [7:0] typ;
        logic [7:0] arg;
    } cmd_t;

    function automatic logic cmd_known(input logic [7:0] t);
        return (t == CMD_QUERY) || (t == CMD_PROG) || (t == CMD_HARD) || (t == CMD_SOFT);
    endfunction

    function automatic logic cmd_needs_arg(input logic [7:0] t);
        return (t == CMD_PROG) || (t == CMD_SOFT);
    endfunction

    function automatic seq_state_e cmd_target(input logic [7:0] t);
        case (t)
            CMD_QUERY: return ST_QUERY;
            CMD_PROG:  return ST_PROG;
            CMD_HARD:  return ST_HARD;
            CMD_SOFT:  return ST_SOFT;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_tx(input seq_state_e s);
        return s[2] & s[0];
    endfunction

endpackage

// File: rtl/seqc_parser.sv
module seqc_parser
    import seqc_pkg::*;
#(
    parameter int HDR_LEN = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               rx_vld,
    input  logic [7:0]         rx_byte,
    input  logic               rx_eop,
    input  logic [7:0]         my_loc,
    output logic               pkt_end,
    output logic               pkt_ok,
    output seq_state_e         pkt_target,
    output cmd_t               cmd_q,
    output logic [MAC_W-1:0]   mac_q
);
    localparam int CNT_MAX = HDR_LEN + 3;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] IX_LOC   = CW'(HDR_LEN);
    localparam logic [CW-1:0] IX_TYP   = CW'(HDR_LEN + 1);
    localparam logic [CW-1:0] IX_ARG   = CW'(HDR_LEN + 2);
    localparam logic [CW-1:0] IX_SAT   = CW'(CNT_MAX);
    localparam logic [CW-1:0] IX_MAC0  = CW'(SRC_MAC_OFS);
    localparam logic [CW-1:0] IX_MACE  = CW'(SRC_MAC_OFS + MAC_BYTES);

    logic [CW-1:0]    cnt, cnt_nx;
    logic [7:0]       loc_sh, typ_sh, arg_sh;
    logic [MAC_W-1:0] mac_sh;
    logic             take, got_typ, got_arg;
    logic [7:0]       eff_loc, eff_typ, eff_arg;

    always_comb begin
        take    = active & rx_vld;
        cnt_nx  = (cnt == IX_SAT) ? cnt : cnt + CW'(1);
        eff_loc = (cnt == IX_LOC) ? rx_byte : loc_sh;
        eff_typ = (cnt == IX_TYP) ? rx_byte : typ_sh;
        eff_arg = (cnt == IX_ARG) ? rx_byte : arg_sh;
        got_typ = cnt_nx >= IX_ARG;
        got_arg = cnt_nx >= IX_SAT;
        pkt_end = take & rx_eop;
        pkt_ok  = got_typ && (eff_loc == my_loc) && cmd_known(eff_typ)
                  && (!cmd_needs_arg(eff_typ) || got_arg);
        pkt_target = cmd_target(eff_typ);
    end

    // Field capture, cleared whenever the reader is not active.
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt    <= '0;
            loc_sh <= '0;
            typ_sh <= '0;
            arg_sh <= '0;
            mac_sh <= '0;
        end else if (take) begin
            cnt <= cnt_nx;
            if (cnt >= IX_MAC0 && cnt < IX_MACE)
                mac_sh <= {mac_sh[MAC_W-9:0], rx_byte};
            if (cnt == IX_LOC) loc_sh <= rx_byte;
            if (cnt == IX_TYP) typ_sh <= rx_byte;
            if (cnt == IX_ARG) arg_sh <= rx_byte;
        end
    end

    // Command fields change only when a packet is accepted.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            mac_q <= '0;
        end else if (pkt_end && pkt_ok) begin
            cmd_q.typ <= eff_typ;
            cmd_q.arg <= got_arg ? eff_arg : 8'h00;
            if (eff_typ == CMD_SOFT)
                mac_q <= mac_sh;
        end
    end
endmodule

// File: rtl/seqc_fsm.sv
module seqc_fsm
    import seqc_pkg::*;
#(
    parameter int CHIP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_nonempty,
    input  logic              pkt_end,
    input  logic              pkt_ok,
    input  seq_state_e        pkt_target,
    input  logic              qry_done,
    input  logic              prg_done,
    input  logic              tx_done,
    input  logic [CHIP_W-1:0] chip_mask,
    output seq_state_e        state,
    output logic              qry_start,
    output logic              prg_start,
    output logic              tx_start,
    output logic              tx_kind,
    output logic [CHIP_W-1:0] chip_rst
);
    seq_state_e state_q, state_nx;
    logic       fresh_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HARD, ST_SOFT: state_nx = ST_TX_STAT;
            ST_IDLE:   if (rx_nonempty) state_nx = ST_READ;
            ST_READ:   if (pkt_end) state_nx = pkt_ok ? pkt_target : ST_IDLE;
            ST_QUERY:  if (!fresh_q && qry_done) state_nx = ST_TX_STAT;
            ST_PROG:   if (!fresh_q && prg_done) state_nx = ST_TX_DAC;
            ST_TX_STAT, ST_TX_DAC:
                       if (!fresh_q && tx_done) state_nx = ST_IDLE;
            default:   state_nx = ST_HARD;
        endcase
    end

    // fresh_q marks the first cycle spent in a state.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HARD;
            fresh_q <= 1'b1;
        end else begin
            state_q <= state_nx;
            fresh_q <= (state_nx != state_q);
        end
    end

    always_comb begin
        state     = state_q;
        qry_start = fresh_q && (state_q == ST_QUERY);
        prg_start = fresh_q && (state_q == ST_PROG);
        tx_start  = fresh_q && is_tx(state_q);
        tx_kind   = is_tx(state_q) & state_q[1];
        case (state_q)
            ST_HARD: chip_rst = '1;
            ST_SOFT: chip_rst = chip_mask;
            default: chip_rst = '0;
        endcase
    end
endmodule

// File: rtl/pkt_cmd_sequencer.sv
module pkt_cmd_sequencer
    import seqc_pkg::*;
#(
    parameter int HDR_LEN = 14,
    parameter int CHIP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_nonempty,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eop,
    input  logic [7:0]        my_loc,
    input  logic              qry_done,
    input  logic              prg_done,
    input  logic              tx_done,
    output logic              qry_start,
    output logic              prg_start,
    output logic              tx_start,
    output logic              tx_kind,
    output logic [CHIP_W-1:0] chip_rst,
    output logic [7:0]        cmd_type,
    output logic [7:0]        cmd_arg,
    output logic [47:0]       peer_mac,
    output logic [2:0]        state_o
);
    seq_state_e       st, pkt_target;
    logic             pkt_end, pkt_ok;
    cmd_t             cmd;
    logic [MAC_W-1:0] mac;

    seqc_parser #(.HDR_LEN(HDR_LEN)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .active     (st == ST_READ),
        .rx_vld     (rx_vld),
        .rx_byte    (rx_byte),
        .rx_eop     (rx_eop),
        .my_loc     (my_loc),
        .pkt_end    (pkt_end),
        .pkt_ok     (pkt_ok),
        .pkt_target (pkt_target),
        .cmd_q      (cmd),
        .mac_q      (mac)
    );

    seqc_fsm #(.CHIP_W(CHIP_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .rx_nonempty (rx_nonempty),
        .pkt_end     (pkt_end),
        .pkt_ok      (pkt_ok),
        .pkt_target  (pkt_target),
        .qry_done    (qry_done),
        .prg_done    (prg_done),
        .tx_done     (tx_done),
        .chip_mask   (cmd.arg[CHIP_W-1:0]),
        .state       (st),
        .qry_start   (qry_start),
        .prg_start   (prg_start),
        .tx_start    (tx_start),
        .tx_kind     (tx_kind),
        .chip_rst    (chip_rst)
    );

    assign cmd_type = cmd.typ;
    assign cmd_arg  = cmd.arg;
    assign peer_mac = mac;
    assign state_o  = st;
endmodule

// File: rtl/seqc_checker.sv
module seqc_checker
    import seqc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rx_nonempty,
    input logic        qry_done,
    input logic        prg_done,
    input logic        tx_done,
    input logic        qry_start,
    input logic        prg_start,
    input logic        tx_start,
    input logic        tx_kind,
    input logic [47:0] peer_mac,
    input logic [2:0]  state_o
);
    p_hard_exit_r1: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_HARD |=> state_o == ST_TX_STAT && tx_start && !tx_kind);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_IDLE && !rx_nonempty |=> state_o == ST_IDLE);

    p_idle_go_r2: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_IDLE && rx_nonempty |=> state_o == ST_READ);

    p_qry_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        qry_start |=> !qry_start);

    p_qry_exit_r5: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_QUERY && qry_done && !qry_start |=> state_o == ST_TX_STAT);

    p_prg_exit_r6: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_PROG && prg_done && !prg_start |=> state_o == ST_TX_DAC && tx_start && tx_kind);

    p_start_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({qry_start, prg_start, tx_start}));

    p_tx_exit_r7: assert property (@(posedge clk) disable iff (rst)
        state_o[2] && state_o[0] && tx_done && !tx_start |=> state_o == ST_IDLE);

    p_soft_exit_r8: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_SOFT |=> state_o == ST_TX_STAT);

    p_mac_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(peer_mac) |-> state_o == ST_SOFT);

    p_done_early_r9: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_QUERY && qry_start |=> state_o == ST_QUERY);
endmodule

bind pkt_cmd_sequencer seqc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_nonempty (rx_nonempty),
    .qry_done    (qry_done),
    .prg_done    (prg_done),
    .tx_done     (tx_done),
    .qry_start   (qry_start),
    .prg_start   (prg_start),
    .tx_start    (tx_start),
    .tx_kind     (tx_kind),
    .peer_mac    (peer_mac),
    .state_o     (state_o)
);

// File: tb/tb_pkt_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_pkt_cmd_sequencer;
    localparam int HDR = 14;

    logic clk = 0;
    logic rst = 1;
    logic rx_nonempty = 0, rx_vld = 0, rx_eop = 0;
    logic [7:0] rx_byte = 0;
    logic [7:0] my_loc = 8'h2A;
    logic qd_r = 0, pd_r = 0, td_r = 0, qd_p = 0, pd_p = 0, td_p = 0;
    logic qry_done, prg_done, tx_done;
    logic qry_start, prg_start, tx_start, tx_kind;
    logic [7:0] chip_rst, cmd_type, cmd_arg;
    logic [47:0] peer_mac;
    logic [2:0] state_o;

    assign qry_done = qd_r | qd_p;
    assign prg_done = pd_r | pd_p;
    assign tx_done  = td_r | td_p;

    always #4 clk = ~clk;

    pkt_cmd_sequencer #(.HDR_LEN(HDR), .CHIP_W(8)) dut (
        .clk(clk), .rst(rst), .rx_nonempty(rx_nonempty), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .rx_eop(rx_eop), .my_loc(my_loc),
        .qry_done(qry_done), .prg_done(prg_done), .tx_done(tx_done),
        .qry_start(qry_start), .prg_start(prg_start), .tx_start(tx_start),
        .tx_kind(tx_kind), .chip_rst(chip_rst), .cmd_type(cmd_type),
        .cmd_arg(cmd_arg), .peer_mac(peer_mac), .state_o(state_o)
    );

    int n_tests = 0, n_fail = 0;
    bit started = 0;
    bit early = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int ms = 0;
    bit mf = 1;
    logic [7:0] m_typ = 0, m_arg = 0;
    logic [47:0] m_mac = 0;
    logic [7:0] mq[$];

    always @(posedge clk) begin
        int nx, n;
        logic [7:0] t;
        bit ok;
        if (rst) begin
            ms = 0; mf = 1; m_typ = 0; m_arg = 0; m_mac = 0; mq.delete();
        end else begin
            nx = ms;
            case (ms)
                0, 1: nx = 5;
                2: if (rx_nonempty) nx = 3;
                3: if (rx_vld) begin
                    mq.push_back(rx_byte);
                    if (rx_eop) begin
                        n = mq.size(); ok = 0; t = 0;
                        if (n >= HDR + 2) begin
                            t = mq[HDR+1];
                            ok = (mq[HDR] == my_loc) &&
                                 (t == 8'h51 || t == 8'h50 || t == 8'h48 || t == 8'h52);
                            if ((t == 8'h50 || t == 8'h52) && n < HDR + 3) ok = 0;
                        end
                        if (ok) begin
                            m_typ = t;
                            m_arg = (n >= HDR + 3) ? mq[HDR+2] : 8'h00;
                            if (t == 8'h52)
                                for (int i = 6; i < 12; i++) m_mac = {m_mac[39:0], mq[i]};
                            nx = (t == 8'h51) ? 4 : (t == 8'h50) ? 6 : (t == 8'h48) ? 0 : 1;
                        end else nx = 2;
                        mq.delete();
                    end
                end
                4: if (!mf && qry_done) nx = 5;
                6: if (!mf && prg_done) nx = 7;
                5, 7: if (!mf && tx_done) nx = 2;
                default: nx = 0;
            endcase
            mf = (nx != ms);
            ms = nx;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            check("R2", "state", 64'(state_o), 64'(ms));
            check("R5", "qry_start", 64'(qry_start), 64'(mf && ms == 4));
            check("R6", "prg_start", 64'(prg_start), 64'(mf && ms == 6));
            check("R7", "tx_start", 64'(tx_start), 64'(mf && (ms == 5 || ms == 7)));
            check("R7", "tx_kind", 64'(tx_kind), 64'(ms == 7));
            check("R8", "chip_rst", 64'(chip_rst),
                  64'((ms == 0) ? 8'hFF : (ms == 1) ? m_arg : 8'h00));
            check("R3", "cmd_type", 64'(cmd_type), 64'(m_typ));
            check("R6", "cmd_arg", 64'(cmd_arg), 64'(m_arg));
            check("R8", "peer_mac", 64'(peer_mac), 64'(m_mac));
        end
    end

    // Sub-unit responders: done three cycles after a start strobe
    int qc = 0, pc = 0, tc = 0;
    always @(negedge clk) begin
        qd_r = 0; pd_r = 0; td_r = 0;
        if (qry_start) begin qc = 3; if (early) qd_r = 1; end
        else if (qc > 0) begin qc--; if (qc == 0) qd_r = 1; end
        if (prg_start) begin pc = 3; if (early) pd_r = 1; end
        else if (pc > 0) begin pc--; if (pc == 0) pd_r = 1; end
        if (tx_start) begin tc = 3; if (early) td_r = 1; end
        else if (tc > 0) begin tc--; if (tc == 0) td_r = 1; end
    end

    task automatic wait_idle();
        int k = 0;
        while (state_o !== 3'b010 && k < 300) begin @(negedge clk); k++; end
    endtask

    // npay: payload bytes kept (loc, type, arg, then filler); cut>0 stops inside header
    task automatic send(input logic [7:0] loc, input logic [7:0] typ, input logic [7:0] arg,
                        input logic [47:0] mac, input int npay, input int cut, input bit gaps);
        logic [7:0] pk[$];
        logic [7:0] pay[5];
        pay = '{loc, typ, arg, 8'h77, 8'h78};
        for (int i = 0; i < HDR; i++)
            pk.push_back((i >= 6 && i < 12) ? mac[47 - 8*(i-6) -: 8] : 8'(8'hE0 + i));
        if (cut > 0) while (pk.size() > cut) void'(pk.pop_back());
        else for (int i = 0; i < npay; i++) pk.push_back(pay[i]);
        rx_nonempty = 1;
        @(negedge clk);
        rx_nonempty = 0;
        for (int i = 0; i < pk.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin rx_vld = 0; @(negedge clk); end
            rx_vld = 1; rx_byte = pk[i]; rx_eop = (i == pk.size() - 1);
            @(negedge clk);
        end
        rx_vld = 0; rx_eop = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;
        check("R1", "reset state", 64'(state_o), 64'(0));
        check("R1", "reset chip_rst", 64'(chip_rst), 64'hFF);
        @(negedge clk);
        check("R1", "status after reset", 64'({state_o, tx_start, tx_kind}), 64'({3'b101, 2'b10}));
        wait_idle();
        repeat (3) @(negedge clk);
        check("R2", "idle holds", 64'(state_o), 64'(2));

        send(8'h2A, 8'h51, 8'h00, 48'h0, 2, 0, 0);
        check("R5", "query cmd", 64'(cmd_type), 64'h51);
        send(8'h2A, 8'h50, 8'hA5, 48'h0, 3, 0, 0);
        check("R6", "dac arg", 64'(cmd_arg), 64'hA5);

        send(8'h2B, 8'h51, 8'h00, 48'h0, 2, 0, 0);
        check("R4", "bad loc keeps type", 64'(cmd_type), 64'h50);
        send(8'h2A, 8'h58, 8'h11, 48'h0, 3, 0, 1);
        check("R4", "bad type keeps arg", 64'(cmd_arg), 64'hA5);
        send(8'h2A, 8'h50, 8'h00, 48'h0, 2, 0, 0);
        check("R4", "P without arg", 64'(cmd_type), 64'h50);
        send(8'h2A, 8'h51, 8'h00, 48'h0, 0, 9, 0);
        check("R4", "short packet", 64'(cmd_arg), 64'hA5);

        send(8'h2A, 8'h52, 8'h3C, 48'h0211_2233_4455, 3, 0, 1);
        check("R8", "peer mac order", 64'(peer_mac), 64'h0211_2233_4455);
        check("R3", "soft arg", 64'(cmd_arg), 64'h3C);
        send(8'h2A, 8'h48, 8'h00, 48'hFFFF_FFFF_FFFF, 2, 0, 0);
        check("R8", "hard keeps mac", 64'(peer_mac), 64'h0211_2233_4455);

        qd_p = 1; pd_p = 1; td_p = 1;
        @(negedge clk);
        qd_p = 0; pd_p = 0; td_p = 0;
        @(negedge clk);
        check("R9", "done in idle ignored", 64'(state_o), 64'(2));

        early = 1;
        send(8'h2A, 8'h51, 8'h00, 48'h0, 5, 0, 1);
        send(8'h2A, 8'h50, 8'h5A, 48'h0, 5, 0, 0);
        early = 0;
        check("R9", "early done ignored", 64'(cmd_arg), 64'h5A);
        check("R7", "back to idle", 64'(state_o), 64'(2));

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule